// File: doc/BRIEF.md
# Passive Serial Configuration Sequencer

This block brings a target FPGA from reset into user mode over a passive serial link. When the host gives a start pulse, the block pulls the target's active-low reset line low and checks that the target acknowledges the reset on its active-low status line. It then releases the reset and polls the status line at fixed intervals until the target reports that it is ready. After a short settle time it shifts the configuration bytes out one bit per data clock, with the least significant bit first. The bytes arrive on a valid/ready stream that carries a last flag.

After the last byte, the block checks the status line again, and it can also check the target's configured flag. If both are good, it sends one byte of zeros as trailing clocks so that the target starts up. The result is reported as a sticky done flag or a sticky error code. A profile select picks one of two timing sets. All intervals are counted from a microsecond strobe, which is derived from the parameterised system clock frequency. Both target inputs pass through two-flop synchronisers before use.

Top module: `pser_loader`

## Requirements
- R1: After reset, `tgt_rst_n_o` is 1, `sclk_o` is 0, and `busy_o`, `done_o` and `err_o` are all 0.
- R2: A start accepted while idle with `partial_i`=0 drives `tgt_rst_n_o` low on the next cycle. The line stays low for exactly `RST_US` microseconds (2 µs by default) in both profiles.
- R3: If the synchronised status is still high at the end of the reset pulse, the block returns to idle with `err_o`=2. In this case `tgt_rst_n_o` stays low until the next start.
- R4: After the reset line is released, the status is sampled once every `POLL_US` (268) µs, measured from the release. If the last allowed sample still reads low, the block ends with `err_o`=3.
- R5: The number of samples is the ceiling of the maximum wait divided by 268. The maximum wait is 1506 µs when `alt_prof_i`=0 (6 samples) and 3000 µs when `alt_prof_i`=1 (12 samples).
- R6: Once a sample reads high, the first rising edge of `sclk_o` comes after a settle wait of 2 µs (`alt_prof_i`=0) or 10 µs (`alt_prof_i`=1), plus two cycles of byte handshake.
- R7: Each byte is sent as 8 `sclk_o` pulses. Each pulse is high for one cycle and low for at least one cycle. `sdo_o` changes only while `sclk_o` is low. `sclk_o` is low whenever the block is idle or the reset line is low.
- R8: With `lsb_first_i`=1, bit 0 of a byte is sent first. With `lsb_first_i`=0, the byte is bit-reversed first, so bit 7 goes out first.
- R9: After the last byte, if the synchronised status is low, the block ends with `err_o`=4 and sends no trailing clocks.
- R10: After the last byte, with `cd_mon_en_i`=1 and the synchronised configured flag low, the block ends with `err_o`=5. With `cd_mon_en_i`=0, the configured flag is ignored.
- R11: On success, the block sends 8 further `sclk_o` pulses with `sdo_o`=0 and then sets `done_o`.
- R12: A start with `partial_i`=1 sets `err_o`=1. It leaves `busy_o` low and does not change `tgt_rst_n_o`.
- R13: `busy_o` is high from the cycle after the start until the block returns to idle. `done_o` and `err_o` hold their values until the next accepted start, and they are never set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted while idle |
| alt_prof_i | input | 1 | 1 selects the alternate timing profile |
| partial_i | input | 1 | Partial reconfiguration request (rejected) |
| lsb_first_i | input | 1 | 1 when bytes already have their first bit in bit 0 |
| cd_mon_en_i | input | 1 | Enables the configured-flag check at the end |
| s_data_i | input | 8 | Stream byte |
| s_valid_i | input | 1 | Stream byte valid |
| s_last_i | input | 1 | Marks the final byte |
| s_ready_o | output | 1 | Stream byte accepted this cycle when valid |
| tgt_rst_n_o | output | 1 | Active-low target reset |
| tgt_ok_i | input | 1 | Target status, low while in reset or on error |
| tgt_cfgd_i | input | 1 | Target configured flag |
| sclk_o | output | 1 | Serial data clock, idle low |
| sdo_o | output | 1 | Serial data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sticky success flag |
| err_o | output | 3 | Sticky error code (0 none, 1 bad request, 2 no reset ack, 3 not ready, 4 config error, 5 configured flag low) |

## Verification
The sequence runs in both profiles with the target's status release placed at different distances into the poll window. The early releases check the sample spacing and the settle delay. A release at 2000 µs succeeds in the alternate profile and times out in the default one, which shows that the two sample counts differ. Byte streams with mixed bit patterns are sent in both bit orders, so a swapped or skipped reversal shows up in the captured bits. Further runs inject a missing reset acknowledge, a status drop during streaming, and a low configured flag with the check both enabled and disabled; together these tell the error codes, their priority and the trailing-clock rule apart.

// File: rtl/pser_pkg.sv
package pser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_POLL,
        ST_SETTLE,
        ST_STREAM,
        ST_CHECK,
        ST_TAIL
    } pser_state_e;

    localparam logic [2:0] ERR_NONE    = 3'd0;
    localparam logic [2:0] ERR_BADREQ  = 3'd1;
    localparam logic [2:0] ERR_NOACK   = 3'd2;
    localparam logic [2:0] ERR_NOTRDY  = 3'd3;
    localparam logic [2:0] ERR_CFG     = 3'd4;
    localparam logic [2:0] ERR_CFGDLOW = 3'd5;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pser_tick.sv
module pser_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick_o = (cnt_q == CW'(DIV - 1));

    always_comb begin
        if (clr_i || tick_o) cnt_d = '0;
        else                 cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pser_sync.sv
module pser_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q, hold_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                hold_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                hold_q <= meta_q;
            end
        end
        assign sync_o[g] = hold_q;
    end
endmodule

// File: rtl/pser_shift.sv
module pser_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] byte_i,
    input  logic         rev_i,
    output logic         sclk_o,
    output logic         sdo_o,
    output logic         empty_o
);
    localparam int NW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [NW-1:0] left;
        logic          hi;
    } shf_t;

    shf_t d, q;
    logic [W-1:0] flipped;

    for (genvar g = 0; g < W; g++) begin : g_flip
        assign flipped[g] = byte_i[W-1-g];
    end

    always_comb begin
        d = q;
        if (load_i) begin
            d.sh   = rev_i ? flipped : byte_i;
            d.left = NW'(W);
            d.hi   = 1'b0;
        end else if (q.left != '0) begin
            if (!q.hi) begin
                d.hi = 1'b1;
            end else begin
                d.hi   = 1'b0;
                d.sh   = q.sh >> 1;
                d.left = q.left - NW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk_o  = q.hi;
    assign sdo_o   = q.sh[0];
    assign empty_o = (q.left == '0);
endmodule

// File: rtl/pser_loader.sv
module pser_loader
    import pser_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int RST_US        = 2,
    parameter int POLL_US       = 268,
    parameter int MAXW_DEF_US   = 1506,
    parameter int MAXW_ALT_US   = 3000,
    parameter int SETTLE_DEF_US = 2,
    parameter int SETTLE_ALT_US = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       alt_prof_i,
    input  logic       partial_i,
    input  logic       lsb_first_i,
    input  logic       cd_mon_en_i,
    input  logic [7:0] s_data_i,
    input  logic       s_valid_i,
    input  logic       s_last_i,
    output logic       s_ready_o,
    output logic       tgt_rst_n_o,
    input  logic       tgt_ok_i,
    input  logic       tgt_cfgd_i,
    output logic       sclk_o,
    output logic       sdo_o,
    output logic       busy_o,
    output logic       done_o,
    output logic [2:0] err_o
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int NS_DEF     = ceil_div(MAXW_DEF_US, POLL_US);
    localparam int NS_ALT     = ceil_div(MAXW_ALT_US, POLL_US);
    localparam int UMAX       = max2(max2(RST_US, POLL_US), max2(SETTLE_DEF_US, SETTLE_ALT_US));
    localparam int UW         = $clog2(UMAX + 1);
    localparam int SW         = $clog2(max2(NS_DEF, NS_ALT) + 1);

    typedef struct packed {
        pser_state_e   state;
        logic          rst_n_out;
        logic          done;
        logic [2:0]    err;
        logic [UW-1:0] us_left;
        logic [SW-1:0] samp_left;
        logic          alt;
        logic          lsb;
        logic          cdmon;
        logic          last;
    } ctl_t;

    ctl_t d, q;

    logic       tick, tick_clr, expire;
    logic       ok_s, cfgd_s, sh_empty, ld;
    logic [7:0] ld_byte;
    logic [1:0] sync_out;

    pser_tick #(.DIV(CYC_PER_US)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tick_clr),
        .tick_o (tick)
    );

    pser_sync #(.W(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({tgt_cfgd_i, tgt_ok_i}),
        .sync_o  (sync_out)
    );
    assign ok_s   = sync_out[0];
    assign cfgd_s = sync_out[1];

    pser_shift #(.W(8)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (ld),
        .byte_i  (ld_byte),
        .rev_i   (!q.lsb),
        .sclk_o  (sclk_o),
        .sdo_o   (sdo_o),
        .empty_o (sh_empty)
    );

    assign expire = tick && (q.us_left == UW'(1));

    always_comb begin
        d       = q;
        ld      = 1'b0;
        ld_byte = '0;
        if (tick && q.us_left != '0) d.us_left = q.us_left - UW'(1);
        case (q.state)
            ST_IDLE: begin
                if (start_i) begin
                    d.done = 1'b0;
                    if (partial_i) begin
                        d.err = ERR_BADREQ;
                    end else begin
                        d.err       = ERR_NONE;
                        d.state     = ST_RST;
                        d.rst_n_out = 1'b0;
                        d.us_left   = UW'(RST_US);
                        d.alt       = alt_prof_i;
                        d.lsb       = lsb_first_i;
                        d.cdmon     = cd_mon_en_i;
                        d.last      = 1'b0;
                    end
                end
            end
            ST_RST: begin
                if (expire) begin
                    if (ok_s) begin
                        d.state = ST_IDLE;
                        d.err   = ERR_NOACK;
                    end else begin
                        d.state     = ST_POLL;
                        d.rst_n_out = 1'b1;
                        d.us_left   = UW'(POLL_US);
                        d.samp_left = q.alt ? SW'(NS_ALT) : SW'(NS_DEF);
                    end
                end
            end
            ST_POLL: begin
                if (expire) begin
                    if (ok_s) begin
                        d.state   = ST_SETTLE;
                        d.us_left = q.alt ? UW'(SETTLE_ALT_US) : UW'(SETTLE_DEF_US);
                    end else if (q.samp_left == SW'(1)) begin
                        d.state = ST_IDLE;
                        d.err   = ERR_NOTRDY;
                    end else begin
                        d.samp_left = q.samp_left - SW'(1);
                        d.us_left   = UW'(POLL_US);
                    end
                end
            end
            ST_SETTLE: begin
                if (expire) d.state = ST_STREAM;
            end
            ST_STREAM: begin
                if (sh_empty) begin
                    if (q.last) begin
                        d.state = ST_CHECK;
                    end else if (s_valid_i) begin
                        ld      = 1'b1;
                        ld_byte = s_data_i;
                        d.last  = s_last_i;
                    end
                end
            end
            ST_CHECK: begin
                d.state = ST_IDLE;
                if (!ok_s) begin
                    d.err = ERR_CFG;
                end else if (q.cdmon && !cfgd_s) begin
                    d.err = ERR_CFGDLOW;
                end else begin
                    d.state = ST_TAIL;
                    ld      = 1'b1;
                end
            end
            ST_TAIL: begin
                if (sh_empty) begin
                    d.state = ST_IDLE;
                    d.done  = 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    assign tick_clr = (d.state != q.state);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.state     <= ST_IDLE;
            q.rst_n_out <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign s_ready_o   = (q.state == ST_STREAM) && sh_empty && !q.last;
    assign tgt_rst_n_o = q.rst_n_out;
    assign busy_o      = (q.state != ST_IDLE);
    assign done_o      = q.done;
    assign err_o       = q.err;
endmodule

// File: rtl/pser_loader_chk.sv
module pser_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       partial_i,
    input logic       busy_o,
    input logic       tgt_rst_n_o,
    input logic       sclk_o,
    input logic       sdo_o,
    input logic       done_o,
    input logic [2:0] err_o
);
    a_r2_start_pulls_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !partial_i) |=> (!tgt_rst_n_o && busy_o));

    a_r12_partial_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && partial_i) |=>
            (err_o == 3'd1 && !busy_o && tgt_rst_n_o == $past(tgt_rst_n_o)));

    a_r7_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdo_o));

    a_r7_clock_one_cycle_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |=> !sclk_o);

    a_r7_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o || !tgt_rst_n_o) |-> !sclk_o);

    a_r13_done_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o == 3'd0));
endmodule

bind pser_loader pser_loader_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .partial_i   (partial_i),
    .busy_o      (busy_o),
    .tgt_rst_n_o (tgt_rst_n_o),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o),
    .done_o      (done_o),
    .err_o       (err_o)
);

// File: tb/pser_loader_tb_top.sv
module pser_loader_tb_top;
    localparam int CHZ = 4_000_000;
    localparam int CPU = 4;
    localparam int BIG = 1 << 30;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, alt_prof_i = 1'b0, partial_i = 1'b0;
    logic       lsb_first_i = 1'b0, cd_mon_en_i = 1'b0;
    logic [7:0] s_data_i = '0;
    logic       s_valid_i = 1'b0, s_last_i = 1'b0, s_ready_o;
    logic       tgt_rst_n_o, tgt_ok_i = 1'b1, tgt_cfgd_i = 1'b0;
    logic       sclk_o, sdo_o, busy_o, done_o;
    logic [2:0] err_o;

    pser_loader #(.CLK_HZ(CHZ)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .alt_prof_i(alt_prof_i),
        .partial_i(partial_i), .lsb_first_i(lsb_first_i), .cd_mon_en_i(cd_mon_en_i),
        .s_data_i(s_data_i), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
        .s_ready_o(s_ready_o), .tgt_rst_n_o(tgt_rst_n_o), .tgt_ok_i(tgt_ok_i),
        .tgt_cfgd_i(tgt_cfgd_i), .sclk_o(sclk_o), .sdo_o(sdo_o), .busy_o(busy_o),
        .done_o(done_o), .err_o(err_o)
    );

    int n_cmp = 0, n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [7:0] flip8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // expected windows (cycle numbers, inclusive) for the per-clock model
    int  lo_a = 1, lo_b = 0, bz_a = 1, bz_b = 0;
    bit  model_on = 1'b0;
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 target reset line", int'(tgt_rst_n_o), (cyc >= lo_a && cyc <= lo_b) ? 0 : 1);
            chk("R13 busy", int'(busy_o), (cyc >= bz_a && cyc <= bz_b) ? 1 : 0);
        end
    end

    // target model
    bit ack_ok = 1'b1, frc_en = 1'b0;
    int rel_cyc = -1, relc = 0, base_rise = 0;
    logic       bits_q[$];
    int         rise_q[$];
    logic       p_sclk = 1'b0;
    always @(negedge clk) begin
        if (!tgt_rst_n_o) begin
            tgt_ok_i = ack_ok ? 1'b0 : 1'b1;
            relc = 0;
        end else if (frc_en && rise_q.size() > base_rise) begin
            tgt_ok_i = 1'b0;
        end else if (!tgt_ok_i) begin
            relc++;
            if (rel_cyc >= 0 && relc >= rel_cyc) tgt_ok_i = 1'b1;
        end
    end

    // serial capture
    always @(negedge clk) begin
        if (sclk_o && !p_sclk) begin
            bits_q.push_back(sdo_o);
            rise_q.push_back(cyc);
        end
        p_sclk = sclk_o;
    end

    // byte source
    logic [7:0] src_q[$];
    bit hs = 1'b0;
    always @(negedge clk) begin
        if (hs) void'(src_q.pop_front());
        s_valid_i = (src_q.size() > 0);
        s_data_i  = (src_q.size() > 0) ? src_q[0] : 8'h00;
        s_last_i  = (src_q.size() == 1);
        hs        = s_valid_i && s_ready_o;
    end

    task automatic run_case(input bit alt, input bit lsb, input bit cdmon, input bit ack,
                            input bit cd, input bit frc, input int rel_us,
                            input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2,
                            input int n);
        int c, r_edge, k, ns, st, t0, endc, outc, bbase, exp_bits, exp_first;
        logic [7:0] bv [3];
        bv[0] = b0; bv[1] = b1; bv[2] = b2;
        @(negedge clk);
        c = cyc;
        ns = alt ? 12 : 6;
        st = alt ? 10 : 2;
        r_edge = c + 1 + 2 * CPU;
        k = (rel_us < 0) ? 99 : rel_us / 268 + 1;
        if (!ack)                 outc = 2;
        else if (k > ns)          outc = 3;
        else if (frc)             outc = 4;
        else if (cdmon && !cd)    outc = 5;
        else                      outc = 0;
        t0 = r_edge + k * 268 * CPU + st * CPU;
        case (outc)
            2:       endc = r_edge;
            3:       endc = r_edge + ns * 268 * CPU;
            4, 5:    endc = t0 + 17 * n + 2;
            default: endc = t0 + 17 * n + 19;
        endcase
        lo_a = c + 1; lo_b = ack ? r_edge - 1 : BIG;
        bz_a = c + 1; bz_b = endc - 1;
        ack_ok = ack; frc_en = frc; tgt_cfgd_i = cd;
        rel_cyc = (rel_us < 0) ? -1 : rel_us * CPU;
        base_rise = rise_q.size();
        bbase = bits_q.size();
        for (int i = 0; i < n; i++) src_q.push_back(bv[i]);
        alt_prof_i = alt; lsb_first_i = lsb; cd_mon_en_i = cdmon; partial_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (cyc < endc + 3) @(negedge clk);
        case (outc)
            2: chk("R3 error code", int'(err_o), 2);
            3: chk("R4 R5 error code", int'(err_o), 3);
            4: chk("R9 error code", int'(err_o), 4);
            5: chk("R10 error code", int'(err_o), 5);
            default: chk("R10 R13 error code", int'(err_o), 0);
        endcase
        chk("R11 done flag", int'(done_o), (outc == 0) ? 1 : 0);
        exp_bits  = (outc == 0) ? 8 * n + 8 : ((outc >= 4) ? 8 * n : 0);
        exp_first = (outc == 0 || outc >= 4) ? t0 + 2 : -1;
        chk("R7 R11 clock pulse count", bits_q.size() - bbase, exp_bits);
        chk("R6 first clock rise cycle",
            (rise_q.size() > base_rise) ? rise_q[base_rise] : -1, exp_first);
        if (bits_q.size() - bbase == exp_bits) begin
            for (int j = 0; j < n && exp_bits > 0; j++) begin
                logic [7:0] got;
                for (int i = 0; i < 8; i++) got[i] = bits_q[bbase + 8 * j + i];
                chk("R8 byte order", int'(got), int'(lsb ? bv[j] : flip8(bv[j])));
            end
            if (outc == 0) begin
                logic [7:0] tl;
                for (int i = 0; i < 8; i++) tl[i] = bits_q[bbase + 8 * n + i];
                chk("R11 trailing zeros", int'(tl), 0);
            end
        end
        src_q.delete();
        frc_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset line", int'(tgt_rst_n_o), 1);
        chk("R1 clock", int'(sclk_o), 0);
        chk("R1 busy", int'(busy_o), 0);
        chk("R1 done", int'(done_o), 0);
        chk("R1 error", int'(err_o), 0);
        model_on = 1'b1;

        // R12: partial request rejected, line untouched
        partial_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; partial_i = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 error code", int'(err_o), 1);
        chk("R12 reset line", int'(tgt_rst_n_o), 1);
        chk("R12 no clock", int'(rise_q.size()), 0);

        // default profile, reversed bytes, monitor on, success
        run_case(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 300,  8'hA5, 8'h3C, 8'h01, 3);
        // alternate profile, bytes already in order, monitor off ignores low flag
        run_case(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 100,  8'hC3, 8'h80, 8'h00, 2);
        // configured flag low with monitor on
        run_case(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1000, 8'h7E, 8'h00, 8'h00, 1);
        // status drop during stream, alternate profile late release
        run_case(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2000, 8'h11, 8'h00, 8'h00, 1);
        // same late release times out in the default profile
        run_case(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2000, 8'h55, 8'h00, 8'h00, 1);
        // never released, alternate profile: 12 samples
        run_case(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, -1,   8'h55, 8'h00, 8'h00, 1);
        // no reset acknowledge: line held low afterwards
        run_case(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 300,  8'h55, 8'h00, 8'h00, 1);
        repeat (20) @(negedge clk);
        chk("R3 line still low", int'(tgt_rst_n_o), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule